// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives several PWM lines, one per channel, from a single free-running period counter. All channels share one duty value. Each channel's on-window is placed directly after the previous channel's window, so the outputs light one after another within each period and are never high together. A typical use is a row of indicators that light in sequence at a common brightness.

The period counter moves forward only on a slow tick. A prescaler inside the block derives that tick from the system clock. A new duty value takes effect only at the start of a period. An enable input freezes the block with all lines dark. A synchronous reset returns the block to the start of a period.

Top module: `phase_pwm`

## Requirements
- R1: While `rst` is high at a clock edge, the period counter and prescaler go to zero, all `pwmOut` bits are low after that edge, and `duty` is captured as the active duty value.
- R2: While `en` is high, the period counter advances by one once every `DIV` clocks. It runs 0, 1, …, `PERIOD`-1 (default 100) and then returns to 0.
- R3: With active duty value d, channel 0 is high for counts 0 through d inclusive, which is d+1 counts.
- R4: Channel k is high for counts k·(d+1) through k·(d+1)+d, so it starts on the count right after channel k-1 ends. Any part of a window past `PERIOD`-1 is dropped and never wraps into the next period. With the defaults and d=19, channel 1 covers counts 20 to 39.
- R5: At most one `pwmOut` bit is high in any cycle.
- R6: While `en` is low, the counter and prescaler hold their values and every `pwmOut` bit is low after the next edge. Operation resumes from the held position when `en` returns high.
- R7: The active duty value is replaced by `duty` only on the tick where the counter wraps from `PERIOD`-1 to 0, or during reset. A change to `duty` in the middle of a period has no effect until the next period.
- R8: `pwmOut` is registered. It shows the window decision for the counter value and duty that were held just before the clock edge that updates it.
- R9: With d=0, each channel whose start count is below `PERIOD` is high for exactly one count per period, and the channels follow one another on consecutive counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low the block freezes and all lines are dark |
| duty | input | CNT_W | Common duty value d; each window spans d+1 counts |
| pwmOut | output | NUM_CH | One PWM line per channel, bit k is channel k |

## Verification
The assertions assume that `rst` and `en` change only between clock edges, and that `duty` is any value that fits in `CNT_W` bits. Values above `PERIOD`-1 are legal and only widen channel 0 to the full period. The stimulus changes `en` and `duty` on the falling edge. It draws duty values over the whole field width, including values past the modulus, and toggles enable and reset at random points inside a period. Directed cases place duty changes in the middle of a period and use duty values of 0, 19, 49 and 99. These values put one window boundary exactly at the end of the period and push the next channel's start past it.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  typedef struct packed {
    logic tick;   // prescaler strobe: counter steps on this cycle
    logic wrap;   // counter steps from PERIOD-1 back to zero
  } pwmStrobe_t;
endpackage

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int PERIOD = 100,
  parameter int DIV    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strb
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

  logic [DIV_W-1:0] divCnt;

  always_comb begin
    strb.tick = en && (divCnt == DIV_LAST);
    strb.wrap = strb.tick && (cnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      cnt    <= '0;
    end else if (en) begin
      if (strb.tick) begin
        divCnt <= '0;
        cnt    <= strb.wrap ? '0 : cnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_pwm_dp.sv
module phase_pwm_dp
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  duty,
  input  logic [CNT_W-1:0]  cnt,
  input  pwmStrobe_t        strb,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [CNT_W-1:0]  dutyReg
);
  // wide enough for NUM_CH*(duty+1)+duty without overflow
  localparam int BW = CNT_W + $clog2(NUM_CH + 1) + 1;

  logic [NUM_CH-1:0] hit;
  logic [BW-1:0]     span;
  logic [BW-1:0]     cntW;

  assign span = BW'(dutyReg) + BW'(1);
  assign cntW = BW'(cnt);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_win
    logic [BW-1:0] lo;
    logic [BW-1:0] hi;
    assign lo = BW'(k) * span;
    assign hi = lo + BW'(dutyReg);
    assign hit[k] = (cntW >= lo) && (cntW <= hi);
  end

  always_ff @(posedge clk) begin
    if (rst || strb.wrap) dutyReg <= duty;
  end

  always_ff @(posedge clk) begin
    if (rst) pwmOut <= '0;
    else     pwmOut <= en ? hit : '0;
  end
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 7,
  parameter int PERIOD = 100,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  duty,
  output logic [NUM_CH-1:0] pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dutyReg;
  pwmStrobe_t       strb;

  phase_pwm_ctrl #(.CNT_W(CNT_W), .PERIOD(PERIOD), .DIV(DIV)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt), .strb(strb)
  );

  phase_pwm_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .en(en), .duty(duty), .cnt(cnt), .strb(strb),
    .pwmOut(pwmOut), .dutyReg(dutyReg)
  );
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 7,
  parameter int PERIOD = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [CNT_W-1:0]  count,
  input pwmStrobe_t        strb,
  input logic [CNT_W-1:0]  dutyReg
);
  logic rstQ;
  always @(posedge clk) rstQ <= rst;

  // R1: the edge after a reset cycle shows a cleared state
  always @(posedge clk) begin
    if (rstQ === 1'b1) begin
      a_r1_reset_clears: assert (pwmOut == '0 && count == '0)
        else $error("reset did not clear state");
    end
  end

  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    count < CNT_W'(PERIOD));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && count != CNT_W'(PERIOD - 1)) |=> count == $past(count) + 1'b1);

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pwmOut));

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> pwmOut == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  a_r7_duty_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> $stable(dutyReg));
endmodule

bind phase_pwm phase_pwm_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pwmOut(pwmOut), .count(cnt),
  .strb(strb), .dutyReg(dutyReg)
);

// File: tb/phase_pwm_bench.sv
module phase_pwm_bench;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 7;
  localparam int PERIOD = 100;
  localparam int DIV    = 4;
  localparam int PD     = PERIOD * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic [CNT_W-1:0] duty = '0;
  logic [NUM_CH-1:0] pwmOut;

  always #10 clk = ~clk;

  phase_pwm #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PERIOD(PERIOD), .DIV(DIV)) u_phase_pwm (
    .clk(clk), .rst(rst), .en(en), .duty(duty), .pwmOut(pwmOut)
  );

  int checks = 0;
  int fails  = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  // reference state built from R1, R2, R6, R7, R8
  int mDiv = 0, mCnt = 0, mDuty = 0;
  logic [NUM_CH-1:0] mOut = '0;

  function automatic logic winHit(int k, int c, int d);
    int lo = k * (d + 1);
    return (c >= lo) && (c <= lo + d);
  endfunction

  function automatic int expHigh(int k, int d);
    int lo = k * (d + 1);
    if (lo >= PERIOD) return 0;
    return (((d + 1) < (PERIOD - lo)) ? (d + 1) : (PERIOD - lo)) * DIV;
  endfunction

  always @(posedge clk) begin
    logic [NUM_CH-1:0] nxt;
    for (int k = 0; k < NUM_CH; k++) nxt[k] = winHit(k, mCnt, mDuty);
    if (rst) begin
      mDiv = 0; mCnt = 0; mDuty = int'(duty); mOut = '0;
    end else begin
      mOut = en ? nxt : '0;
      if (en) begin
        if (mDiv == DIV - 1) begin
          mDiv = 0;
          if (mCnt == PERIOD - 1) begin mCnt = 0; mDuty = int'(duty); end
          else mCnt = mCnt + 1;
        end else mDiv = mDiv + 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn && !done) begin
      check(pwmOut == mOut, "R3/R4/R8 cycle model", int'(pwmOut), int'(mOut));
      check($onehot0(pwmOut), "R5 one line at a time", int'(pwmOut), 0);
    end
  end

  task automatic doReset(int d);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; duty = CNT_W'(d);
    @(negedge clk);
    modelOn = 1'b1;
    check(pwmOut == '0, "R1 outputs low in reset", int'(pwmOut), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(output int h[NUM_CH]);
    for (int k = 0; k < NUM_CH; k++) h[k] = 0;
    repeat (PD) begin
      @(negedge clk);
      for (int k = 0; k < NUM_CH; k++) h[k] += int'(pwmOut[k]);
    end
  endtask

  task automatic dirTest(int a, int b);
    int h[NUM_CH];
    doReset(a);
    duty = CNT_W'(b);
    measure(h);
    for (int k = 0; k < NUM_CH; k++)
      check(h[k] == expHigh(k, a), "R3 R4 R7 R9 first period keeps old duty", h[k], expHigh(k, a));
    measure(h);
    for (int k = 0; k < NUM_CH; k++)
      check(h[k] == expHigh(k, b), "R2 R3 R4 R9 next period uses new duty", h[k], expHigh(k, b));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finishRun();
  end

  initial begin
    int r;
    r = $urandom(32'h5EED);
    dirTest(19, 49);
    dirTest(0, 99);
    dirTest(99, 33);
    dirTest(49, 0);
    dirTest(127, 19);

    // R6: freeze mid-period, then resume
    doReset(30);
    repeat (157) @(negedge clk);
    en = 1'b0;
    repeat (37) begin
      @(negedge clk);
      check(pwmOut == '0, "R6 lines dark while disabled", int'(pwmOut), 0);
    end
    en = 1'b1;
    repeat (PD) @(negedge clk);

    // random mix of duty changes, enable drops and resets
    repeat (20000) begin
      @(negedge clk);
      r = int'($urandom % 200);
      if (r < 4) duty = CNT_W'($urandom % 128);
      if (r >= 10 && r < 14) en = ~en;
      rst = (r == 199);
    end
    rst = 1'b0; en = 1'b1;
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule